// File: doc/BRIEF.md
# Two-Slot Exclusive Reservation Tracker

This block sits beside the address channels of a memory slave and decides, for every locked (exclusive) store, whether the store may reach memory. It watches read and write address events from `NUM_PORTS` slave ports. Each event carries an ID, an address, a beat count minus one, a burst kind and a lock flag. The block never touches data. A locked read opens a reservation over the bytes its burst covers, tagged with the requester's ID. A locked write is allowed through only if its ID and byte range still match a live reservation.

Two reservation slots exist. Any write that actually reaches memory kills every reservation it overlaps, whatever port it came in on and whether or not it was locked. A locked read can take a slot away from an owner that has not yet written back. The earlier owner's store then fails. A failed locked store is answered with a plain OKAY, and its commit gate stays low so the memory array drops the data. Every response is registered and appears one clock after the event.

Top module: `excl_mon`

## Requirements
- R1: A burst's byte range is computed as follows. For burst kind 1 (incrementing), the range runs from the address rounded down to a `BEAT_BYTES` boundary, for (len+1) beats. For burst kind 2 (wrapping), it is the (len+1)*`BEAT_BYTES`-byte block that is aligned to its own size and holds the address. A locked store matches a reservation when its ID is equal and both range ends are equal, so a wrapping burst and an incrementing burst that cover the same bytes do match.
- R2: A locked read with burst kind 1, or with burst kind 2 and a legal length, answers EXOKAY (`rd_rsp_exok`=1) one cycle later and opens a reservation. A read without lock answers with `rd_rsp_exok`=0 and opens nothing.
- R3: A locked read with burst kind 0 (fixed), with kind 3, or with kind 2 and a length other than 1, 3, 7 or 15 answers `rd_rsp_exok`=0 and opens no reservation. A locked write with such a burst always fails.
- R4: A locked write answers EXOKAY with `wr_commit`=1 only if all three hold: a reservation exists with the same ID, it has the same range, and it is still live.
- R5: A failed locked write answers `wr_rsp_exok`=0 with `wr_commit`=0. It clears no reservation.
- R6: Every committed write clears each reservation whose range it overlaps by at least one byte, whether it is locked or not. A write whose range does not overlap leaves the reservation intact.
- R7: A successful locked write clears its own reservation, so a repeat of that write fails.
- R8: A locked read is placed as follows. If a live reservation already has the same ID, it is overwritten in place. Otherwise the read takes a free slot, lowest index first. If neither slot is free, it replaces the slot allocated longest ago, tracked by a one-bit age pointer. The previous owner's locked write then fails.
- R9: Two reservations with different IDs can be live at the same time. Two live reservations never share an ID.
- R10: When several writes arrive in one cycle, they are judged in port order, lowest index first. A commit on a lower port clears overlapping reservations before a higher port is judged. The judgement otherwise uses the state from the cycle before.
- R11: Locked reads in a cycle are applied after that cycle's write clearing. A reservation opened in the same cycle as an overlapping write survives.
- R12: A write without lock answers `wr_rsp_exok`=0 with `wr_commit`=1.
- R13: Synchronous active-high `rst` empties both slots and drives all response outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld | input | NUM_PORTS | Read address event valid, one bit per port |
| rd_lock | input | NUM_PORTS | Read event is locked (exclusive) |
| rd_id | input | NUM_PORTS*ID_W | Read requester ID, port p at [p*ID_W +: ID_W] |
| rd_addr | input | NUM_PORTS*ADDR_W | Read start byte address |
| rd_len | input | NUM_PORTS*4 | Read beats minus one |
| rd_burst | input | NUM_PORTS*2 | Read burst kind: 0 fixed, 1 incrementing, 2 wrapping |
| wr_vld | input | NUM_PORTS | Write address event valid |
| wr_lock | input | NUM_PORTS | Write event is locked (exclusive) |
| wr_id | input | NUM_PORTS*ID_W | Write requester ID |
| wr_addr | input | NUM_PORTS*ADDR_W | Write start byte address |
| wr_len | input | NUM_PORTS*4 | Write beats minus one |
| wr_burst | input | NUM_PORTS*2 | Write burst kind |
| rd_rsp_vld | output | NUM_PORTS | Read response valid, one cycle after the event |
| rd_rsp_exok | output | NUM_PORTS | Read answer is EXOKAY |
| wr_rsp_vld | output | NUM_PORTS | Write response valid, one cycle after the event |
| wr_rsp_exok | output | NUM_PORTS | Write answer is EXOKAY |
| wr_commit | output | NUM_PORTS | Write data may be stored in memory |

## Verification
Two situations can land in the same cycle. In one, a store on one port kills a reservation while a locked store on another port is judged against it. In the other, a reservation is opened while an overlapping store commits. The bench drives such pairs together on ports 0 and 1. It swaps which port carries the locked store: the locked store must fail when the lower port writes over it, and must succeed when it is on the lower port. For a read opened together with an overlapping store, it checks that a follow-up locked store by the reader gets EXOKAY.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

    // Slot choice for a new reservation among two slots.
    function automatic logic pick_slot(input logic [1:0] live,
                                       input logic [1:0] owned,
                                       input logic       oldest);
        logic s;
        if (owned[0])      s = 1'b0;
        else if (owned[1]) s = 1'b1;
        else if (!live[0]) s = 1'b0;
        else if (!live[1]) s = 1'b1;
        else               s = oldest;
        return s;
    endfunction

endpackage

// File: rtl/excl_range_calc.sv
module excl_range_calc #(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        len,
    input  logic [1:0]        burst,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi,
    output logic              legal
);
    import excl_mon_pkg::*;

    localparam int              BEAT_LG   = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] BEAT_MASK = ADDR_W'(BEAT_BYTES - 1);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] wrap_lo;

    always_comb begin
        base    = addr & ~BEAT_MASK;
        span    = (ADDR_W'(len) + ADDR_W'(1)) << BEAT_LG;
        wrap_lo = addr & ~(span - ADDR_W'(1));
        lo      = base;
        hi      = base | BEAT_MASK;
        legal   = 1'b0;
        case (burst_kind_e'(burst))
            BK_INCR: begin
                lo    = base;
                hi    = base + span - ADDR_W'(1);
                legal = 1'b1;
            end
            BK_WRAP: begin
                lo    = wrap_lo;
                hi    = wrap_lo + span - ADDR_W'(1);
                legal = (len == 4'd1) || (len == 4'd3) ||
                        (len == 4'd7) || (len == 4'd15);
            end
            default: begin
                lo    = base;
                hi    = base | BEAT_MASK;
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/excl_entry_cmp.sv
module excl_entry_cmp #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int N_ENT  = 2
) (
    input  logic [ID_W-1:0]                 req_id,
    input  logic [ADDR_W-1:0]               req_lo,
    input  logic [ADDR_W-1:0]               req_hi,
    input  logic [N_ENT-1:0][ID_W-1:0]      ent_id,
    input  logic [N_ENT-1:0][ADDR_W-1:0]    ent_lo,
    input  logic [N_ENT-1:0][ADDR_W-1:0]    ent_hi,
    output logic [N_ENT-1:0]                exact,
    output logic [N_ENT-1:0]                overlap
);

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign exact[e]   = (req_id == ent_id[e]) &&
                            (req_lo == ent_lo[e]) &&
                            (req_hi == ent_hi[e]);
        assign overlap[e] = (req_lo <= ent_hi[e]) && (req_hi >= ent_lo[e]);
    end

endmodule

// File: rtl/excl_mon.sv
module excl_mon #(
    parameter int NUM_PORTS  = 2,
    parameter int ID_W       = 4,
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          rd_vld,
    input  logic [NUM_PORTS-1:0]          rd_lock,
    input  logic [NUM_PORTS*ID_W-1:0]     rd_id,
    input  logic [NUM_PORTS*ADDR_W-1:0]   rd_addr,
    input  logic [NUM_PORTS*4-1:0]        rd_len,
    input  logic [NUM_PORTS*2-1:0]        rd_burst,
    input  logic [NUM_PORTS-1:0]          wr_vld,
    input  logic [NUM_PORTS-1:0]          wr_lock,
    input  logic [NUM_PORTS*ID_W-1:0]     wr_id,
    input  logic [NUM_PORTS*ADDR_W-1:0]   wr_addr,
    input  logic [NUM_PORTS*4-1:0]        wr_len,
    input  logic [NUM_PORTS*2-1:0]        wr_burst,
    output logic [NUM_PORTS-1:0]          rd_rsp_vld,
    output logic [NUM_PORTS-1:0]          rd_rsp_exok,
    output logic [NUM_PORTS-1:0]          wr_rsp_vld,
    output logic [NUM_PORTS-1:0]          wr_rsp_exok,
    output logic [NUM_PORTS-1:0]          wr_commit
);
    import excl_mon_pkg::*;

    localparam int N_ENT = 2;

    typedef struct packed {
        logic [N_ENT-1:0]              vld;
        logic [N_ENT-1:0][ID_W-1:0]    id;
        logic [N_ENT-1:0][ADDR_W-1:0]  lo;
        logic [N_ENT-1:0][ADDR_W-1:0]  hi;
        logic                          age;
        logic [NUM_PORTS-1:0]          rrv;
        logic [NUM_PORTS-1:0]          rrx;
        logic [NUM_PORTS-1:0]          wrv;
        logic [NUM_PORTS-1:0]          wrx;
        logic [NUM_PORTS-1:0]          wcm;
    } mon_st_t;

    mon_st_t st_d, st_q;

    // Per-port burst ranges and comparisons against the stored slots.
    logic [ADDR_W-1:0] r_lo    [NUM_PORTS];
    logic [ADDR_W-1:0] r_hi    [NUM_PORTS];
    logic              r_legal [NUM_PORTS];
    logic [ADDR_W-1:0] w_lo    [NUM_PORTS];
    logic [ADDR_W-1:0] w_hi    [NUM_PORTS];
    logic              w_legal [NUM_PORTS];
    logic [N_ENT-1:0]  w_exact [NUM_PORTS];
    logic [N_ENT-1:0]  w_ovl   [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        excl_range_calc #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_rd_rng (
            .addr  (rd_addr[p*ADDR_W +: ADDR_W]),
            .len   (rd_len[p*4 +: 4]),
            .burst (rd_burst[p*2 +: 2]),
            .lo    (r_lo[p]),
            .hi    (r_hi[p]),
            .legal (r_legal[p])
        );
        excl_range_calc #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_wr_rng (
            .addr  (wr_addr[p*ADDR_W +: ADDR_W]),
            .len   (wr_len[p*4 +: 4]),
            .burst (wr_burst[p*2 +: 2]),
            .lo    (w_lo[p]),
            .hi    (w_hi[p]),
            .legal (w_legal[p])
        );
        excl_entry_cmp #(.ID_W(ID_W), .ADDR_W(ADDR_W), .N_ENT(N_ENT)) u_wr_cmp (
            .req_id  (wr_id[p*ID_W +: ID_W]),
            .req_lo  (w_lo[p]),
            .req_hi  (w_hi[p]),
            .ent_id  (st_q.id),
            .ent_lo  (st_q.lo),
            .ent_hi  (st_q.hi),
            .exact   (w_exact[p]),
            .overlap (w_ovl[p])
        );
    end

    logic [N_ENT-1:0] live;
    logic [N_ENT-1:0] owned;
    logic             slot;
    logic             pass;

    always_comb begin
        st_d     = st_q;
        st_d.rrv = '0;
        st_d.rrx = '0;
        st_d.wrv = '0;
        st_d.wrx = '0;
        st_d.wcm = '0;
        live     = st_q.vld;
        owned    = '0;
        slot     = 1'b0;
        pass     = 1'b0;

        // Write phase: port order, lower index commits first.
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_vld[p]) begin
                st_d.wrv[p] = 1'b1;
                if (wr_lock[p]) begin
                    pass        = w_legal[p] && ((w_exact[p] & live) != '0);
                    st_d.wrx[p] = pass;
                    st_d.wcm[p] = pass;
                end else begin
                    st_d.wcm[p] = 1'b1;
                end
                if (st_d.wcm[p]) begin
                    live = live & ~w_ovl[p];
                end
            end
        end
        st_d.vld = live;

        // Read phase: reservations placed after write clearing.
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_vld[p]) begin
                st_d.rrv[p] = 1'b1;
                if (rd_lock[p] && r_legal[p]) begin
                    st_d.rrx[p] = 1'b1;
                    for (int e = 0; e < N_ENT; e++) begin
                        owned[e] = st_d.vld[e] &&
                                   (st_d.id[e] == rd_id[p*ID_W +: ID_W]);
                    end
                    slot = pick_slot(st_d.vld, owned, st_d.age);
                    st_d.vld[slot] = 1'b1;
                    st_d.id[slot]  = rd_id[p*ID_W +: ID_W];
                    st_d.lo[slot]  = r_lo[p];
                    st_d.hi[slot]  = r_hi[p];
                    st_d.age       = ~slot;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
        end else begin
            st_q     <= st_d;
        end
    end

    assign rd_rsp_vld  = st_q.rrv;
    assign rd_rsp_exok = st_q.rrx;
    assign wr_rsp_vld  = st_q.wrv;
    assign wr_rsp_exok = st_q.wrx;
    assign wr_commit   = st_q.wcm;

    // Slot-state properties.
    AST_IDS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (&st_q.vld) |-> (st_q.id[0] != st_q.id[1])); // R9
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.vld == '0 && wr_commit == '0 && rd_rsp_exok == '0)); // R13

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        AST_RD_EXOK_CAUSE: assert property (@(posedge clk) disable iff (rst)
            rd_rsp_exok[p] |-> $past(rd_vld[p] && rd_lock[p])); // R2
        AST_EXOK_HAD_RESV: assert property (@(posedge clk) disable iff (rst)
            wr_rsp_exok[p] |-> $past(st_q.vld != '0)); // R4
        AST_FAIL_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
            (wr_rsp_vld[p] && !wr_rsp_exok[p] && $past(wr_lock[p])) |-> !wr_commit[p]); // R5
        AST_PLAIN_COMMIT: assert property (@(posedge clk) disable iff (rst)
            (wr_rsp_vld[p] && $past(!wr_lock[p])) |-> (wr_commit[p] && !wr_rsp_exok[p])); // R12
    end

endmodule

// File: tb/excl_mon_tb_top.sv
`timescale 1ns/1ps
module excl_mon_tb_top;

    localparam int NP = 2;
    localparam int IW = 4;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NP-1:0]    rd_vld, rd_lock, wr_vld, wr_lock;
    logic [NP*IW-1:0] rd_id, wr_id;
    logic [NP*AW-1:0] rd_addr, wr_addr;
    logic [NP*4-1:0]  rd_len, wr_len;
    logic [NP*2-1:0]  rd_burst, wr_burst;
    logic [NP-1:0]    rd_rsp_vld, rd_rsp_exok, wr_rsp_vld, wr_rsp_exok, wr_commit;

    excl_mon #(.NUM_PORTS(NP), .ID_W(IW), .ADDR_W(AW), .BEAT_BYTES(4)) dut_i (
        .clk(clk), .rst(rst),
        .rd_vld(rd_vld), .rd_lock(rd_lock), .rd_id(rd_id), .rd_addr(rd_addr),
        .rd_len(rd_len), .rd_burst(rd_burst),
        .wr_vld(wr_vld), .wr_lock(wr_lock), .wr_id(wr_id), .wr_addr(wr_addr),
        .wr_len(wr_len), .wr_burst(wr_burst),
        .rd_rsp_vld(rd_rsp_vld), .rd_rsp_exok(rd_rsp_exok),
        .wr_rsp_vld(wr_rsp_vld), .wr_rsp_exok(wr_rsp_exok), .wr_commit(wr_commit)
    );

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    localparam logic [1:0] FIX = 2'd0, INC = 2'd1, WRP = 2'd2;

    typedef struct packed {
        logic        is_wr;
        logic        lock;
        logic [3:0]  id;
        logic [31:0] addr;
        logic [3:0]  len;
        logic [1:0]  burst;
        logic        exok;
        logic        commit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,4'd1, 32'h100,4'd3,INC,1'b1,1'b0,4'd2},  // R2 open
        '{1'b1,1'b1,4'd1, 32'h100,4'd3,INC,1'b1,1'b1,4'd4},  // R4 success
        '{1'b1,1'b1,4'd1, 32'h100,4'd3,INC,1'b0,1'b0,4'd7},  // R7 repeat fails
        '{1'b0,1'b1,4'd2, 32'h200,4'd0,INC,1'b1,1'b0,4'd2},  // R2
        '{1'b1,1'b0,4'd5, 32'h202,4'd0,INC,1'b0,1'b1,4'd12}, // R12 plain, overlaps
        '{1'b1,1'b1,4'd2, 32'h200,4'd0,INC,1'b0,1'b0,4'd6},  // R6 cleared
        '{1'b0,1'b1,4'd3, 32'h304,4'd3,WRP,1'b1,1'b0,4'd1},  // R1 wrap 0x300..0x30F
        '{1'b0,1'b1,4'd4, 32'h400,4'd1,INC,1'b1,1'b0,4'd9},  // R9 second slot
        '{1'b0,1'b1,4'd6, 32'h500,4'd0,INC,1'b1,1'b0,4'd8},  // R8 evicts oldest (id3)
        '{1'b1,1'b1,4'd3, 32'h304,4'd3,WRP,1'b0,1'b0,4'd8},  // R8 evicted owner fails
        '{1'b1,1'b1,4'd4, 32'h400,4'd1,INC,1'b1,1'b1,4'd9},  // R9 other slot intact
        '{1'b0,1'b1,4'd6, 32'h600,4'd0,INC,1'b1,1'b0,4'd8},  // R8 same ID in place
        '{1'b1,1'b1,4'd6, 32'h500,4'd0,INC,1'b0,1'b0,4'd4},  // R4 old range gone
        '{1'b1,1'b1,4'd6, 32'h600,4'd0,INC,1'b1,1'b1,4'd8},  // R8 new range
        '{1'b0,1'b1,4'd7, 32'h700,4'd0,FIX,1'b0,1'b0,4'd3},  // R3 fixed read
        '{1'b1,1'b1,4'd7, 32'h700,4'd0,FIX,1'b0,1'b0,4'd3},  // R3 fixed write
        '{1'b0,1'b1,4'd7, 32'h700,4'd2,WRP,1'b0,1'b0,4'd3},  // R3 bad wrap length
        '{1'b1,1'b1,4'd7, 32'h700,4'd0,INC,1'b0,1'b0,4'd3},  // R3 nothing opened
        '{1'b0,1'b1,4'd8, 32'h808,4'd3,WRP,1'b1,1'b0,4'd1},  // R1
        '{1'b1,1'b1,4'd8, 32'h800,4'd3,INC,1'b1,1'b1,4'd1},  // R1 same bytes match
        '{1'b0,1'b1,4'd9, 32'h900,4'd0,INC,1'b1,1'b0,4'd6},  // R6
        '{1'b1,1'b0,4'd1, 32'h904,4'd0,INC,1'b0,1'b1,4'd6},  // R6 no overlap
        '{1'b1,1'b1,4'd9, 32'h900,4'd0,INC,1'b1,1'b1,4'd6},  // R6 survived
        '{1'b0,1'b0,4'd1, 32'h900,4'd0,INC,1'b0,1'b0,4'd2},  // R2 plain read
        '{1'b1,1'b1,4'd1, 32'h900,4'd0,INC,1'b0,1'b0,4'd2},  // R2 nothing opened
        '{1'b0,1'b1,4'd10,32'hA00,4'd0,INC,1'b1,1'b0,4'd5},  // R5 setup
        '{1'b1,1'b1,4'd11,32'hA00,4'd0,INC,1'b0,1'b0,4'd4}   // R4 wrong ID
    };

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic clr();
        rd_vld = '0; rd_lock = '0; rd_id = '0; rd_addr = '0; rd_len = '0; rd_burst = '0;
        wr_vld = '0; wr_lock = '0; wr_id = '0; wr_addr = '0; wr_len = '0; wr_burst = '0;
    endtask

    task automatic set_rd(input int p, input logic lk, input logic [3:0] id,
                          input logic [31:0] a, input logic [3:0] l, input logic [1:0] b);
        rd_vld[p] = 1'b1; rd_lock[p] = lk; rd_id[p*IW +: IW] = id;
        rd_addr[p*AW +: AW] = a; rd_len[p*4 +: 4] = l; rd_burst[p*2 +: 2] = b;
    endtask

    task automatic set_wr(input int p, input logic lk, input logic [3:0] id,
                          input logic [31:0] a, input logic [3:0] l, input logic [1:0] b);
        wr_vld[p] = 1'b1; wr_lock[p] = lk; wr_id[p*IW +: IW] = id;
        wr_addr[p*AW +: AW] = a; wr_len[p*4 +: 4] = l; wr_burst[p*2 +: 2] = b;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        clr();
        rst = 1'b1;
        repeat (3) step();
        // R13 outputs low in reset
        chk("R13", "rd_rsp_vld in reset", |rd_rsp_vld, 1'b0);
        chk("R13", "wr_commit in reset", |wr_commit, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v  = VECS[i];
            rq = $sformatf("R%0d", v.req);
            if (v.is_wr) set_wr(0, v.lock, v.id, v.addr, v.len, v.burst);
            else         set_rd(0, v.lock, v.id, v.addr, v.len, v.burst);
            step();
            if (v.is_wr) begin
                chk(rq, $sformatf("vec %0d wr_rsp_vld", i), wr_rsp_vld[0], 1'b1);
                chk(rq, $sformatf("vec %0d wr_rsp_exok", i), wr_rsp_exok[0], v.exok);
                chk(rq, $sformatf("vec %0d wr_commit", i), wr_commit[0], v.commit);
            end else begin
                chk(rq, $sformatf("vec %0d rd_rsp_vld", i), rd_rsp_vld[0], 1'b1);
                chk(rq, $sformatf("vec %0d rd_rsp_exok", i), rd_rsp_exok[0], v.exok);
            end
            clr();
        end

        // R5: failed write by id11 left id10's reservation alive
        set_wr(0, 1'b1, 4'd10, 32'hA00, 4'd0, INC); step();
        chk("R5", "owner after foreign fail exok", wr_rsp_exok[0], 1'b1);
        clr();

        // R10: lower port plain write kills before higher port locked write
        set_rd(0, 1'b1, 4'd1, 32'hB00, 4'd0, INC); step(); clr();
        set_wr(0, 1'b0, 4'd3, 32'hB00, 4'd0, INC);
        set_wr(1, 1'b1, 4'd1, 32'hB00, 4'd0, INC); step();
        chk("R10", "p0 plain commit", wr_commit[0], 1'b1);
        chk("R10", "p1 locked exok", wr_rsp_exok[1], 1'b0);
        chk("R10", "p1 locked commit", wr_commit[1], 1'b0);
        clr();

        // R10: locked write on lower port wins over same-cycle plain write
        set_rd(0, 1'b1, 4'd2, 32'hC00, 4'd0, INC); step(); clr();
        set_wr(0, 1'b1, 4'd2, 32'hC00, 4'd0, INC);
        set_wr(1, 1'b0, 4'd5, 32'hC00, 4'd0, INC); step();
        chk("R10", "p0 locked exok", wr_rsp_exok[0], 1'b1);
        chk("R10", "p1 plain commit", wr_commit[1], 1'b1);
        clr();

        // R9: two reservations opened and consumed in the same cycles
        set_rd(0, 1'b1, 4'd3, 32'hD00, 4'd0, INC);
        set_rd(1, 1'b1, 4'd4, 32'hD40, 4'd0, INC); step();
        chk("R9", "dual read p0", rd_rsp_exok[0], 1'b1);
        chk("R9", "dual read p1", rd_rsp_exok[1], 1'b1);
        clr();
        set_wr(0, 1'b1, 4'd4, 32'hD40, 4'd0, INC);
        set_wr(1, 1'b1, 4'd3, 32'hD00, 4'd0, INC); step();
        chk("R9", "dual write p0", wr_rsp_exok[0], 1'b1);
        chk("R9", "dual write p1", wr_rsp_exok[1], 1'b1);
        clr();

        // R13: reset drops a reservation
        set_rd(0, 1'b1, 4'd5, 32'hE00, 4'd0, INC); step(); clr();
        rst = 1'b1; step(); rst = 1'b0;
        set_wr(0, 1'b1, 4'd5, 32'hE00, 4'd0, INC); step();
        chk("R13", "write after reset exok", wr_rsp_exok[0], 1'b0);
        chk("R13", "write after reset commit", wr_commit[0], 1'b0);
        clr();

        // R11: read opened alongside an overlapping commit survives
        set_wr(0, 1'b0, 4'd1, 32'hF00, 4'd0, INC);
        set_rd(1, 1'b1, 4'd6, 32'hF00, 4'd0, INC); step();
        chk("R11", "same-cycle read exok", rd_rsp_exok[1], 1'b1);
        clr();
        set_wr(0, 1'b1, 4'd6, 32'hF00, 4'd0, INC); step();
        chk("R11", "reservation survived", wr_rsp_exok[0], 1'b1);
        clr();

        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule